// File: doc/BRIEF.md
# Interrupt coalescing holdoff controller

This block sits between one channel's completion-event strobe and that channel's level interrupt line. It lowers the interrupt rate by disarming itself each time it raises the interrupt. The line stays high until software writes the run code to the channel control register. That write rearms the channel and starts a holdoff of a programmable number of microseconds. Events that arrive while the channel is disarmed or holding off are collapsed into one pending flag. That flag is delivered as a single interrupt once the holdoff has run out.

Software sets the holdoff from its backlog, for example a few microseconds per outstanding work item, capped at the field maximum. The microsecond time base is a prescaler of the core clock with a parameterized divide ratio `TICK_DIV`. The prescaler restarts at each holdoff start, so a holdoff of D microseconds lasts exactly D·`TICK_DIV` clock cycles.

Top module: `irq_holdoff_ctrl`

## Requirements
- R1: After reset, `irq_o` is low, the channel is armed with no pending event, and the delay register (byte address 0x0C) reads 0x8000.
- R2: When the channel is armed, not holding off, and `event_i` is high at a clock edge, `irq_o` is high from that edge on.
- R3: Once high, `irq_o` stays high and further events raise no second interrupt until software writes 0x0001 (the run code) to the control register at byte address 0x00. `irq_o` is low from the edge of that write.
- R4: A run-code write while the interrupt is high starts a holdoff of D microseconds, where D is the delay field. An event latched before or during the holdoff raises `irq_o` exactly D·TICK_DIV+1 cycles after the rearm edge.
- R5: A delay of 0 means no holdoff: a pending event raises `irq_o` one cycle after the rearm edge.
- R6: Any number of events latched while the channel is disarmed or holding off yield exactly one interrupt. After that interrupt has been rearmed, `irq_o` stays low when no new event arrives.
- R7: Bits 13:0 of the delay register store the written value. Bit 15 always reads 1 and bit 14 always reads 0, whatever is written to them.
- R8: A delay written during a running holdoff does not change that holdoff. It applies from the next rearm.
- R9: Control writes of any value other than the run code are ignored. A run-code write while the interrupt is low is ignored and does not restart a running holdoff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` (combinational) |
| event_i | input | 1 | Completion event strobe, sampled every cycle |
| irq_o | output | 1 | Level interrupt output |

## Verification
The assertions assume that `reg_we_i` and `event_i` are synchronous single-cycle strobes. They also assume that a register write is a whole 16-bit word presented together with its address in the same cycle. The bench drives every input on the falling edge, and each write or event is exactly one cycle wide. The bench reads outputs on the falling edge. It times every holdoff in whole cycles counted from the rearm write edge, so the prescaler phase is always known to it.

// File: rtl/irq_holdoff_pkg.sv
`timescale 1ns/1ps
package irq_holdoff_pkg;
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_HOLD   = 2'd1,
    ST_MASKED = 2'd2
  } chan_state_e;

  localparam logic [7:0]  ADDR_CTRL  = 8'h00;
  localparam logic [7:0]  ADDR_DELAY = 8'h0C;
  localparam logic [15:0] RUN_CODE   = 16'h0001;
endpackage

// File: rtl/irq_holdoff_regs.sv
`timescale 1ns/1ps
module irq_holdoff_regs
  import irq_holdoff_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DLY_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DLY_W-1:0]  delay_o,
  output logic              rearm_o
);
  localparam int CAP_BIT = DATA_W - 1;

  logic [DLY_W-1:0] delay_q;
  logic             hit_dly, hit_ctl;

  assign hit_dly = (addr_i == ADDR_W'(ADDR_DELAY));
  assign hit_ctl = (addr_i == ADDR_W'(ADDR_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              delay_q <= '0;
    else if (we_i && hit_dly) delay_q <= wdata_i[DLY_W-1:0];
  end

  assign rearm_o = we_i && hit_ctl && (wdata_i == DATA_W'(RUN_CODE));
  assign delay_o = delay_q;

  // Capability flag is hardwired; bits between it and the field read zero
  always_comb begin
    rdata_o = '0;
    if (hit_dly) begin
      rdata_o[DLY_W-1:0] = delay_q;
      rdata_o[CAP_BIT]   = 1'b1;
    end
  end

  a_r7_delay_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_dly) |=> (delay_o == $past(wdata_i[DLY_W-1:0])));

  a_r7_delay_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && hit_dly) |=> $stable(delay_o));
endmodule

// File: rtl/irq_holdoff_tick.sv
`timescale 1ns/1ps
module irq_holdoff_tick #(
  parameter int TICK_DIV = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (TICK_DIV > 1) begin : g_gap
      a_r4_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
      a_r4_tick_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/irq_holdoff_fsm.sv
`timescale 1ns/1ps
module irq_holdoff_fsm
  import irq_holdoff_pkg::*;
#(
  parameter int DLY_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic             rearm_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             tick_i,
  output logic             hold_start_o,
  output logic             irq_o
);
  chan_state_e      st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             irq_q, irq_d;

  always_comb begin
    st_d         = st_q;
    cnt_d        = cnt_q;
    pend_d       = pend_q;
    irq_d        = irq_q;
    hold_start_o = 1'b0;
    unique case (st_q)
      ST_ARMED: begin
        if (event_i || pend_q) begin
          st_d   = ST_MASKED;
          irq_d  = 1'b1;
          pend_d = 1'b0;
        end
      end
      ST_MASKED: begin
        if (event_i) pend_d = 1'b1;
        if (rearm_i) begin
          irq_d        = 1'b0;
          cnt_d        = delay_i;
          hold_start_o = 1'b1;
          st_d         = (delay_i == '0) ? ST_ARMED : ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (event_i) pend_d = 1'b1;
        if (tick_i) begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == DLY_W'(1)) st_d = ST_ARMED;
        end
      end
      default: st_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ARMED;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;

  a_r2_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED && (event_i || pend_q)) |=> irq_o);

  a_r3_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rearm_i) |=> irq_o);

  a_r3_irq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && rearm_i) |=> !irq_o);

  a_r4_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD) |-> !irq_o);

  a_r8_cnt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && !tick_i) |=> (st_q == ST_HOLD && $stable(cnt_q)));

  a_r6_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && st_q != ST_ARMED) |=> pend_q);
endmodule

// File: rtl/irq_holdoff_ctrl.sv
`timescale 1ns/1ps
module irq_holdoff_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int DLY_W    = 14,
  parameter int TICK_DIV = 250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              event_i,
  output logic              irq_o
);
  logic [DLY_W-1:0] delay;
  logic             rearm, hold_start, tick;

  irq_holdoff_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .we_i    (reg_we_i),
    .rdata_o (reg_rdata_o),
    .delay_o (delay),
    .rearm_o (rearm)
  );

  irq_holdoff_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (hold_start),
    .tick_o (tick)
  );

  irq_holdoff_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .event_i      (event_i),
    .rearm_i      (rearm),
    .delay_i      (delay),
    .tick_i       (tick),
    .hold_start_o (hold_start),
    .irq_o        (irq_o)
  );
endmodule

// File: tb/irq_holdoff_ctrl_bench.sv
`timescale 1ns/1ps
module irq_holdoff_ctrl_bench;
  localparam int DIV = 3;
  localparam logic [7:0] A_CTL = 8'h00;
  localparam logic [7:0] A_DLY = 8'h0C;
  localparam logic [15:0] RUN = 16'h0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [15:0] rdata;
  logic        ev = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_holdoff_ctrl #(.TICK_DIV(DIV)) u_irq_holdoff_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_rdata_o(rdata), .event_i(ev), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse_ev();
    ev = 1'b1;
    @(negedge clk);
    ev = 1'b0;
  endtask

  task automatic wait_rise(input int lim, output int n);
    n = 0;
    while (!irq && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] vals [7] = '{16'h0000, 16'hFFFF, 16'h4000, 16'h8000,
                              16'h3FFF, 16'h1234, 16'hC005};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    addr = A_DLY;
    #0.1;
    chk("R1 delay readback", rdata, 16'h8000);

    // R2 armed event
    pulse_ev();
    chk("R2 first fire", irq, 1);

    // R3 held, extra event latched, non-run control write ignored (R9)
    pulse_ev();
    chk("R3 held under event", irq, 1);
    wr(A_CTL, 16'h0002);
    chk("R9 non-run code ignored", irq, 1);

    // R4/R5 holdoff sweep
    for (int d = 0; d <= 12; d++) begin
      wr(A_DLY, 16'(d));
      wr(A_CTL, RUN);
      chk("R3 drop on rearm", irq, 0);
      wait_rise(200, n);
      chk(d == 0 ? "R5 zero delay" : "R4 holdoff length", n, d * DIV + 1);
      pulse_ev();
    end

    // R6 several latched events give one interrupt
    pulse_ev();
    pulse_ev();
    wr(A_DLY, 16'h0000);
    wr(A_CTL, RUN);
    wait_rise(50, n);
    chk("R6 single delivery", n, 1);
    wr(A_CTL, RUN);
    repeat (6) @(negedge clk);
    chk("R6 no second interrupt", irq, 0);

    // R7 delay register field behaviour
    foreach (vals[i]) begin
      wr(A_DLY, vals[i]);
      chk("R7 readback", rdata, 16'h8000 | (vals[i] & 16'h3FFF));
    end

    // R2 event after an expired holdoff with nothing pending
    pulse_ev();
    wr(A_DLY, 16'd2);
    wr(A_CTL, RUN);
    repeat (10) @(negedge clk);
    chk("R2 idle after holdoff", irq, 0);
    pulse_ev();
    chk("R2 fire after holdoff", irq, 1);

    // R8 delay rewritten during holdoff
    wr(A_DLY, 16'd5);
    wr(A_CTL, RUN);
    wr(A_DLY, 16'd20);
    pulse_ev();
    wait_rise(500, n);
    chk("R8 running holdoff unchanged", n + 2, 5 * DIV + 1);
    pulse_ev();
    wr(A_CTL, RUN);
    wait_rise(500, n);
    chk("R8 new delay next holdoff", n, 20 * DIV + 1);

    // R9 run code during holdoff does not restart it
    pulse_ev();
    wr(A_DLY, 16'd4);
    wr(A_CTL, RUN);
    wr(A_CTL, RUN);
    wait_rise(500, n);
    chk("R9 no restart", n + 1, 4 * DIV + 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule